// File: doc/BRIEF.md
# Coherency unit register block

This block is the control and status register window of a small multicore cluster's coherency unit. A simple register bus reaches it. Each access carries an 8-bit offset into a 256-byte window, a read strobe or a write strobe, an access size given as a byte count, and 32 bits of write data. The block holds three things: a one-bit enable, a configuration word that is fixed by the core-count parameter, and a 32-bit power-status word. Software can reach the power-status word as whole words, half-words or single bytes.

The power-status word is visible at four consecutive byte offsets. A sub-word access at one of these offsets works on the byte lanes that start at that offset. Lanes that would fall past the top of the word are dropped. A write whose size is not 1, 2 or 4 bytes is discarded completely. The reserved offsets, the invalidate register, the filter-address registers and the access-control registers all read as zero and take no action on a write. The coherency machinery itself is not part of this block.

Read data is registered. It appears in the cycle after the read strobe and holds until the next read.

Top module: `cohu_regs`

## Requirements
- R1: A write of a valid size at offset 0x00 stores bit 0 of the write data as the enable. A read at 0x00 returns the enable in bit 0, and bits 31:1 read as zero.
- R2: A read at offset 0x04 returns N-1 in bits [1:0] and ones in bits [4+N-1:4], where N is the CORES parameter (1 to 4, default 1). All other bits read as zero. With the default this word is 0x00000010.
- R3: Offset 0x04 is read-only. A write there changes neither the enable nor the power-status word.
- R4: A read at offset 0x08+k (k = 0..3) returns the power-status word shifted right by 8*k bits, with zeros filled in from the top.
- R5: A write at offset 0x08+k with size S of 1, 2 or 4 bytes replaces status bytes k through k+S-1 with write-data bytes 0 through S-1. Bytes at positions above 3 are discarded, and all other status bytes keep their value.
- R6: A write whose size field (a byte count) is not 1, 2 or 4 changes no state, whatever its offset.
- R7: All other offsets read as zero, and writes to them change no state. This covers 0x0C (invalidate), 0x40 and 0x44 (filter range), 0x50 and 0x54 (access control), and every offset not listed in R1 to R5.
- R8: A synchronous active-high reset clears the enable, the power-status word and the read-data register.
- R9: Read data is loaded at the clock edge that samples the read strobe. It is held unchanged in every cycle that has no read strobe. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4 are valid) |
| bus_wdata | input | 32 | Write data, least significant byte in lane 0 |
| bus_rdata | output | 32 | Registered read data |

## Verification
Some properties are checked on every cycle. These are the upper enable bits reading zero, the constant configuration word, zero reads from every other offset, and the holding of read data between strobes. Every cycle also confirms that writes to read-only or reserved offsets leave the state unchanged, and that writes with a bad size do the same. Full-word status writes and the effect of reset on the stored state are checked each cycle as well. Only the bench scenarios show that sub-word lane merges keep the other bytes intact. The same holds for truncation of lanes past the top byte and for the right-shifted view at each byte offset, because these depend on the sequence of earlier writes.

// File: rtl/cohu_pkg.sv
package cohu_pkg;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_CFG  = 8'h04;
    localparam logic [5:0] OFF_PWR_HI = 6'h02; // 0x08..0x0B share addr[7:2]

    typedef enum logic [1:0] {
        RGN_CTRL,
        RGN_CFG,
        RGN_PWR,
        RGN_ZERO
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [1:0] lane;
    } decode_t;

    function automatic logic size_ok(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [31:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/cohu_addr_dec.sv
module cohu_addr_dec
    import cohu_pkg::*;
(
    input  logic [7:0] addr,
    output decode_t    dec
);
    always_comb begin
        dec.lane = addr[1:0];
        if (addr == OFF_CTRL)
            dec.region = RGN_CTRL;
        else if (addr == OFF_CFG)
            dec.region = RGN_CFG;
        else if (addr[7:2] == OFF_PWR_HI)
            dec.region = RGN_PWR;
        else
            dec.region = RGN_ZERO;
    end
endmodule

// File: rtl/cohu_cfg_word.sv
module cohu_cfg_word #(
    parameter int DATA_W = 32,
    parameter int CORES  = 1
) (
    output logic [DATA_W-1:0] word
);
    localparam int MASK_LSB = 4;
    localparam int MAX_CORES = 4;

    logic [MAX_CORES-1:0] present;

    for (genvar c = 0; c < MAX_CORES; c++) begin : g_core
        assign present[c] = (c < CORES);
    end

    always_comb begin
        word = '0;
        word[1:0] = 2'(CORES - 1);
        word[MASK_LSB +: MAX_CORES] = present;
    end
endmodule

// File: rtl/cohu_pwr_lanes.sv
module cohu_pwr_lanes
    import cohu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        lane,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status
);
    localparam int LANES = DATA_W / 8;
    localparam int SH_W  = $clog2(DATA_W);

    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] lane_data;

    always_comb begin
        shamt     = SH_W'({lane, 3'b000});
        lane_mask = size_mask(size) << shamt;
        lane_data = (wdata & size_mask(size)) << shamt;
    end

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                status[b*8 +: 8] <= '0;
            else if (we && lane_mask[b*8])
                status[b*8 +: 8] <= lane_data[b*8 +: 8];
        end
    end
endmodule

// File: rtl/cohu_regs.sv
module cohu_regs
    import cohu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CORES  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [2:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int SH_W = $clog2(DATA_W);

    decode_t           dec;
    logic              wr_ok;
    logic              ctrl_q;
    logic [DATA_W-1:0] pwr_q;
    logic [DATA_W-1:0] cfg_w;
    logic [DATA_W-1:0] rd_mux;

    cohu_addr_dec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    cohu_cfg_word #(.DATA_W(DATA_W), .CORES(CORES)) u_cfg (
        .word (cfg_w)
    );

    assign wr_ok = bus_wr && size_ok(bus_size);

    cohu_pwr_lanes #(.DATA_W(DATA_W)) u_pwr (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_ok && dec.region == RGN_PWR),
        .lane   (dec.lane),
        .size   (bus_size),
        .wdata  (bus_wdata),
        .status (pwr_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= 1'b0;
        else if (wr_ok && dec.region == RGN_CTRL)
            ctrl_q <= bus_wdata[0];
    end

    always_comb begin
        case (dec.region)
            RGN_CTRL: rd_mux = {{(DATA_W-1){1'b0}}, ctrl_q};
            RGN_CFG:  rd_mux = cfg_w;
            RGN_PWR:  rd_mux = pwr_q >> SH_W'({dec.lane, 3'b000});
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/cohu_regs_chk.sv
module cohu_regs_chk #(
    parameter int DATA_W = 32,
    parameter int CORES  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [2:0]        bus_size,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              ctrl_q,
    input logic [DATA_W-1:0] pwr_q
);
    logic [DATA_W-1:0] cfg_exp;
    logic              mapped;
    logic              good_sz;

    always_comb begin
        cfg_exp = DATA_W'((((1 << CORES) - 1) << 4) | (CORES - 1));
        mapped  = (bus_addr == 8'h00) || (bus_addr == 8'h04) ||
                  (bus_addr >= 8'h08 && bus_addr <= 8'h0B);
        good_sz = (bus_size == 3'd1) || (bus_size == 3'd2) || (bus_size == 3'd4);
    end

    a_r1_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h00) |=> (bus_rdata[DATA_W-1:1] == '0));

    a_r2_cfg_word: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h04) |=> (bus_rdata == cfg_exp));

    a_r3_cfg_read_only: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h04) |=> ($stable(ctrl_q) && $stable(pwr_q)));

    a_r5_full_word_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h08 && bus_size == 3'd4) |=> (pwr_q == $past(bus_wdata)));

    a_r6_bad_size_dropped: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !good_sz) |=> ($stable(ctrl_q) && $stable(pwr_q)));

    a_r7_reserved_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !mapped) |=> (bus_rdata == '0));

    a_r7_reserved_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !mapped) |=> ($stable(ctrl_q) && $stable(pwr_q)));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (ctrl_q == 1'b0 && pwr_q == '0 && bus_rdata == '0));

    a_r9_hold_without_read: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind cohu_regs cohu_regs_chk #(.DATA_W(DATA_W), .CORES(CORES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ctrl_q    (ctrl_q),
    .pwr_q     (pwr_q)
);

// File: tb/cohu_regs_test.sv
module cohu_regs_test;
    localparam int CLK_P = 10;
    localparam int NV    = 33;

    // entry: {is_wr, req[3:0], addr[7:0], size[2:0], wdata[31:0], expect[31:0]}
    localparam logic [79:0] VEC [NV] = '{
        {1'b0, 4'd8, 8'h08, 3'd4, 32'h0,          32'h0000_0000},
        {1'b0, 4'd1, 8'h00, 3'd4, 32'h0,          32'h0000_0000},
        {1'b1, 4'd1, 8'h00, 3'd4, 32'hFFFF_FFFF,  32'h0},
        {1'b0, 4'd1, 8'h00, 3'd4, 32'h0,          32'h0000_0001},
        {1'b0, 4'd2, 8'h04, 3'd4, 32'h0,          32'h0000_0010},
        {1'b1, 4'd5, 8'h08, 3'd4, 32'h1234_5678,  32'h0},
        {1'b0, 4'd4, 8'h08, 3'd4, 32'h0,          32'h1234_5678},
        {1'b0, 4'd4, 8'h09, 3'd1, 32'h0,          32'h0012_3456},
        {1'b0, 4'd4, 8'h0B, 3'd4, 32'h0,          32'h0000_0012},
        {1'b1, 4'd5, 8'h09, 3'd1, 32'hAABB_CCDD,  32'h0},
        {1'b0, 4'd5, 8'h08, 3'd4, 32'h0,          32'h1234_DD78},
        {1'b1, 4'd5, 8'h0A, 3'd2, 32'h0000_BEEF,  32'h0},
        {1'b0, 4'd5, 8'h08, 3'd4, 32'h0,          32'hBEEF_DD78},
        {1'b1, 4'd5, 8'h0B, 3'd4, 32'h1122_3344,  32'h0},
        {1'b0, 4'd5, 8'h08, 3'd4, 32'h0,          32'h44EF_DD78},
        {1'b1, 4'd6, 8'h08, 3'd3, 32'h0,          32'h0},
        {1'b0, 4'd6, 8'h08, 3'd4, 32'h0,          32'h44EF_DD78},
        {1'b1, 4'd6, 8'h00, 3'd0, 32'h0,          32'h0},
        {1'b0, 4'd6, 8'h00, 3'd4, 32'h0,          32'h0000_0001},
        {1'b1, 4'd3, 8'h04, 3'd4, 32'h0,          32'h0},
        {1'b0, 4'd3, 8'h04, 3'd4, 32'h0,          32'h0000_0010},
        {1'b0, 4'd3, 8'h00, 3'd4, 32'h0,          32'h0000_0001},
        {1'b1, 4'd7, 8'h40, 3'd4, 32'hFFFF_FFFF,  32'h0},
        {1'b1, 4'd7, 8'h0C, 3'd4, 32'h0,          32'h0},
        {1'b0, 4'd7, 8'h40, 3'd4, 32'h0,          32'h0000_0000},
        {1'b0, 4'd7, 8'h08, 3'd4, 32'h0,          32'h44EF_DD78},
        {1'b0, 4'd7, 8'h0C, 3'd4, 32'h0,          32'h0000_0000},
        {1'b0, 4'd7, 8'h44, 3'd4, 32'h0,          32'h0000_0000},
        {1'b0, 4'd7, 8'h54, 3'd4, 32'h0,          32'h0000_0000},
        {1'b0, 4'd7, 8'h01, 3'd4, 32'h0,          32'h0000_0000},
        {1'b1, 4'd5, 8'h0A, 3'd1, 32'h0000_0055,  32'h0},
        {1'b0, 4'd4, 8'h0A, 3'd1, 32'h0,          32'h0000_4455},
        {1'b0, 4'd5, 8'h08, 3'd4, 32'h0,          32'h4455_DD78}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;

    cohu_regs uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R8", bus_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][79])
                do_wr(VEC[i][74:67], VEC[i][66:64], VEC[i][63:32]);
            else begin
                do_rd(VEC[i][74:67], got);
                check(tag(VEC[i][78:75]), got, VEC[i][31:0]);
            end
        end

        // R5: half-word at top byte keeps only byte 3
        do_wr(8'h0B, 3'd2, 32'h0000_AB12);
        do_rd(8'h08, got);
        check("R5", got, 32'h1255_DD78);

        // R9: read data held while no read strobe
        do_rd(8'h00, got);
        check("R9", got, 32'h0000_0001);
        @(negedge clk);
        bus_addr = 8'h04;
        repeat (3) @(negedge clk);
        check("R9", bus_rdata, 32'h0000_0001);

        // R9: read in the same cycle as a write returns the old value
        @(negedge clk);
        bus_addr = 8'h00; bus_size = 3'd4; bus_wdata = 32'h0;
        bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R9", bus_rdata, 32'h0000_0001);
        do_rd(8'h00, got);
        check("R1", got, 32'h0000_0000);

        // R8: reset in mid-run clears enable and status
        do_wr(8'h00, 3'd1, 32'h1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R8", bus_rdata, 32'h0);
        do_rd(8'h00, got);
        check("R8", got, 32'h0);
        do_rd(8'h08, got);
        check("R8", got, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        checks++;
        errors++;
        $display("FAIL R9: watchdog expired, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule